// File: doc/BRIEF.md
# Down-Spread Clock Modulation Profile Generator

This block drives the frequency control word of a digitally controlled oscillator so that the synthesized clock sweeps slowly in frequency. Sweeping spreads the clock's spectral energy and lowers the peak emission. The output is always the live nominal word minus an offset. The offset rises from zero to a programmed depth and falls back to zero once per modulation period. Because the offset is only ever subtracted, the oscillator never runs faster than nominal, so the clock period is never shorter than nominal.

The offset advances on a slow tick that is a programmable fraction of the block clock. Each half of the sweep lasts a power-of-two number of ticks. Together, the tick divider and the half-period exponent place the modulation rate in the tens of kilohertz for a typical reference clock. The depth is given in control-word units, which lets software set anything from a fraction of a percent to a few percent of nominal. Two sweep shapes are offered: a linear triangle, and a cusp shape built from four linear pieces that is steep at the turning points and shallow in between. New settings are taken only when the offset is zero, so a reprogramming can never kink the sweep beyond its bound.

Top module: `ssc_profile_gen`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) leaves the offset at zero and the sweep direction rising. It also stops the sweep, so that `ctrl_word` equals `nominal_word` and `period_start` is low in the cycle that follows.
- R2: While the sweep is idle (disabled), `ctrl_word` equals `nominal_word` in every cycle.
- R3: `ctrl_word` is never above `nominal_word`. It equals `nominal_word` minus the offset, or 0 when the offset exceeds `nominal_word`.
- R4: The offset never exceeds `spread_depth`. It reaches exactly `spread_depth` at the end of the rising half.
- R5: The sweep starts on the edge that first sees `spread_en` high while idle. One tick occurs every `step_div`+1 cycles after that edge. Each half lasts H = 2^L ticks, where L is `half_log` clamped to the range 2..10. A full period is therefore 2·H·(`step_div`+1) cycles.
- R6: With `cusp_sel`=0 (triangle), the offset after k ticks of the rising half is floor(D·k/H), and after k ticks of the falling half it is floor(D·(H−k)/H), where D is the depth.
- R7: With `cusp_sel`=1 (cusp), each half is split into four equal quarters of ticks with weights 3,1,1,3. If C(k) is the sum of the weights of the first k ticks, the offset is floor(D·C(k)/(2H)) on the rising half and floor(D·(2H−C(k))/(2H)) on the falling half.
- R8: `spread_en`, `spread_depth`, `step_div`, `half_log` and `cusp_sel` are sampled only while idle or on the edge that closes a period. A change made in mid-period has no effect before that edge, and a dropped enable lets the current period finish.
- R9: `period_start` is high for exactly one cycle, in the cycle after the edge that returns the offset to zero at the end of each period, and low in all other cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| spread_en | input | 1 | Request to sweep; sampled at period boundaries |
| nominal_word | input | CW_W | Unmodulated control word (live) |
| spread_depth | input | DEV_W | Peak offset in control-word units |
| step_div | input | DIV_W | Cycles per tick minus one |
| half_log | input | clog2(HALF_LOG_MAX+1) | log2 of ticks per half period, clamped |
| cusp_sel | input | 1 | 0 triangle, 1 four-piece cusp |
| ctrl_word | output | CW_W | Modulated control word |
| period_start | output | 1 | One-cycle marker when a period closes |

## Verification
A corrupted sweep accumulator shows up at the first tick after the fault. `ctrl_word` then leaves the closed-form value for that tick count, and it misses the exact depth or the exact return to nominal at the next turning point. A wrong direction bit or tick counter moves `period_start` away from the expected cycle count within one period. A settings register that reloads at the wrong time is visible as soon as the next tick uses the new depth or shape in mid-sweep. For that reason, every cycle of every sweep is compared against the formula, and the measured period length and deepest point are compared with tabulated values.

// File: rtl/ssc_profile_gen.sv
module ssc_profile_gen #(
  parameter int CW_W         = 24,
  parameter int DEV_W        = 16,
  parameter int DIV_W        = 12,
  parameter int HALF_LOG_MAX = 10
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  spread_en,
  input  logic [CW_W-1:0]                       nominal_word,
  input  logic [DEV_W-1:0]                      spread_depth,
  input  logic [DIV_W-1:0]                      step_div,
  input  logic [$clog2(HALF_LOG_MAX+1)-1:0]     half_log,
  input  logic                                  cusp_sel,
  output logic [CW_W-1:0]                       ctrl_word,
  output logic                                  period_start
);
  localparam int HL_W  = $clog2(HALF_LOG_MAX+1);
  localparam int NUM_W = DEV_W + HALF_LOG_MAX + 1;
  localparam int PH_W  = HALF_LOG_MAX;

  logic             act_en, act_cusp, dir_dn;
  logic [DEV_W-1:0] act_dev;
  logic [DIV_W-1:0] act_div, div_cnt;
  logic [HL_W-1:0]  act_log, lg_in;
  logic [PH_W-1:0]  phase, ph_mask;
  logic [NUM_W-1:0] num, dev_n, inc, peak, num_up, num_dn;
  logic [NUM_W:0]   up_sum;
  logic [1:0]       seg, weight;
  logic [DEV_W-1:0] offset;
  logic [CW_W-1:0]  off_w;
  logic             tick, ph_last;

  always_comb begin
    if (half_log < HL_W'(2))                 lg_in = HL_W'(2);
    else if (half_log > HL_W'(HALF_LOG_MAX)) lg_in = HL_W'(HALF_LOG_MAX);
    else                                     lg_in = half_log;
  end

  assign ph_mask = {PH_W{1'b1}} >> (HALF_LOG_MAX - int'(act_log));
  assign ph_last = (phase == ph_mask);
  assign seg     = 2'(phase >> (act_log - HL_W'(2)));
  assign tick    = act_en && (div_cnt == act_div);

  always_comb begin
    if (!act_cusp)                       weight = 2'd2;
    else if (seg == 2'd0 || seg == 2'd3) weight = 2'd3;
    else                                 weight = 2'd1;
  end

  assign dev_n = NUM_W'(act_dev);

  always_comb begin
    case (weight)
      2'd1:    inc = dev_n;
      2'd2:    inc = dev_n << 1;
      default: inc = dev_n + (dev_n << 1);
    endcase
  end

  assign peak   = dev_n << (act_log + HL_W'(1));
  assign up_sum = {1'b0, num} + {1'b0, inc};
  assign num_up = (up_sum > {1'b0, peak}) ? peak : up_sum[NUM_W-1:0];
  assign num_dn = (num < inc) ? '0 : num - inc;

  assign offset    = DEV_W'(num >> (act_log + HL_W'(1)));
  assign off_w     = CW_W'(offset);
  assign ctrl_word = (off_w > nominal_word) ? '0 : nominal_word - off_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_en       <= 1'b0;
      act_cusp     <= 1'b0;
      act_dev      <= '0;
      act_div      <= '0;
      act_log      <= HL_W'(2);
      num          <= '0;
      phase        <= '0;
      dir_dn       <= 1'b0;
      div_cnt      <= '0;
      period_start <= 1'b0;
    end else begin
      period_start <= 1'b0;
      if (!act_en) begin
        act_en   <= spread_en;
        act_cusp <= cusp_sel;
        act_dev  <= spread_depth;
        act_div  <= step_div;
        act_log  <= lg_in;
        num      <= '0;
        phase    <= '0;
        dir_dn   <= 1'b0;
        div_cnt  <= '0;
      end else if (tick) begin
        div_cnt <= '0;
        phase   <= ph_last ? '0 : phase + PH_W'(1);
        if (!dir_dn) begin
          num    <= ph_last ? peak : num_up;
          dir_dn <= ph_last;
        end else begin
          num <= ph_last ? '0 : num_dn;
          if (ph_last) begin
            dir_dn       <= 1'b0;
            period_start <= 1'b1;
            act_en       <= spread_en;
            act_cusp     <= cusp_sel;
            act_dev      <= spread_depth;
            act_div      <= step_div;
            act_log      <= lg_in;
          end
        end
      end else begin
        div_cnt <= div_cnt + DIV_W'(1);
      end
    end
  end
endmodule

module ssc_profile_gen_chk #(
  parameter int CW_W  = 24,
  parameter int DEV_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             act_en,
  input logic [DEV_W-1:0] offset,
  input logic [DEV_W-1:0] act_dev,
  input logic [CW_W-1:0]  ctrl_word,
  input logic [CW_W-1:0]  nominal_word,
  input logic             period_start
);
  // R3
  down_spread_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl_word <= nominal_word);
  // R4
  depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
    offset <= act_dev);
  // R9
  marker_zero_chk: assert property (@(posedge clk) disable iff (rst)
    period_start |-> offset == '0);
  // R9
  marker_width_chk: assert property (@(posedge clk) disable iff (rst)
    period_start |=> !period_start);
  // R8
  reload_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(act_dev) |-> offset == '0);
  // R2
  idle_nominal_chk: assert property (@(posedge clk) disable iff (rst)
    !act_en |-> ctrl_word == nominal_word);
endmodule

bind ssc_profile_gen ssc_profile_gen_chk #(.CW_W(CW_W), .DEV_W(DEV_W)) u_chk (
  .clk(clk), .rst(rst), .act_en(act_en), .offset(offset), .act_dev(act_dev),
  .ctrl_word(ctrl_word), .nominal_word(nominal_word), .period_start(period_start)
);

// File: tb/ssc_profile_gen_test.sv
`timescale 1ns/1ps
module ssc_profile_gen_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        spread_en = 1'b0;
  logic [23:0] nominal_word = 24'h100000;
  logic [15:0] spread_depth = '0;
  logic [11:0] step_div = '0;
  logic [3:0]  half_log = '0;
  logic        cusp_sel = 1'b0;
  logic [23:0] ctrl_word;
  logic        period_start;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ssc_profile_gen uut (
    .clk(clk), .rst(rst), .spread_en(spread_en), .nominal_word(nominal_word),
    .spread_depth(spread_depth), .step_div(step_div), .half_log(half_log),
    .cusp_sel(cusp_sel), .ctrl_word(ctrl_word), .period_start(period_start)
  );

  typedef struct packed {
    logic [15:0] dev;
    logic [3:0]  hl;
    logic [11:0] dv;
    logic        cusp;
    logic [23:0] nom;
    logic [31:0] per;
    logic [23:0] minw;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{16'd1000,  4'd3,  12'd0, 1'b0, 24'h100000, 32'd16,   24'd1047576},
    '{16'd777,   4'd4,  12'd2, 1'b1, 24'h200000, 32'd96,   24'd2096375},
    '{16'd65535, 4'd2,  12'd1, 1'b1, 24'h7FFFFF, 32'd16,   24'd8323072},
    '{16'd5,     4'd0,  12'd0, 1'b0, 24'h001000, 32'd8,    24'd4091},
    '{16'd300,   4'd15, 12'd0, 1'b0, 24'h000100, 32'd2048, 24'd0},
    '{16'd0,     4'd3,  12'd3, 1'b1, 24'h0ABCDE, 32'd64,   24'd703710}
  };

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int clamp_lg(input int hl);
    return (hl < 2) ? 2 : ((hl > 10) ? 10 : hl);
  endfunction

  function automatic longint exp_off(input longint dev, input int lg, input bit cusp, input longint m);
    longint h, k, c;
    h = longint'(1) << lg;
    k = (m <= h) ? m : m - h;
    c = 0;
    for (longint j = 0; j < k; j++) begin
      int s;
      s = int'((j * 4) / h);
      c += cusp ? ((s == 0 || s == 3) ? 3 : 1) : 2;
    end
    if (m <= h) return (dev * c) / (2 * h);
    return (dev * (2 * h - c)) / (2 * h);
  endfunction

  // Walks one period (c = 1..P after the starting edge) and compares every cycle.
  task automatic run_period(input longint dev, input int hl, input int dv, input bit cusp,
                            input longint nom, input int drop_at, input int swap_at,
                            output int meas_per, output longint min_ctrl);
    int lg, p;
    lg = clamp_lg(hl);
    p = 2 * (1 << lg) * (dv + 1);
    meas_per = -1;
    min_ctrl = nom;
    for (int c = 1; c <= p; c++) begin
      longint off, ec;
      @(posedge clk); @(negedge clk);
      off = exp_off(dev, lg, cusp, longint'(c / (dv + 1)));
      ec = (off > nom) ? 0 : nom - off;
      chk(ctrl_word == ec, cusp ? "R7 cusp word" : "R6 triangle word", ctrl_word, ec);
      chk(ctrl_word <= nom, "R3 down-spread", ctrl_word, nom);
      chk(period_start == (c == p), "R9 marker", period_start, c == p);
      if (period_start && meas_per < 0) meas_per = c;
      if (ctrl_word < min_ctrl) min_ctrl = ctrl_word;
      if (c == drop_at) spread_en = 1'b0;
      if (c == swap_at) begin
        spread_depth = 16'd900; cusp_sel = 1'b1; step_div = 12'd0; half_log = 4'd3;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R5 watchdog actual=%0d expected=%0d", 150000, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int mp;
    longint mc;
    spread_en = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(ctrl_word == nominal_word, "R1 reset word", ctrl_word, nominal_word);
    chk(period_start == 1'b0, "R1 reset marker", period_start, 0);
    spread_en = 1'b0;
    rst = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R2: idle passes nominal
    nominal_word = 24'h0F0F0F;
    #1;
    chk(ctrl_word == 24'h0F0F0F, "R2 idle word", ctrl_word, 24'h0F0F0F);

    foreach (VECS[i]) begin
      @(negedge clk);
      spread_depth = VECS[i].dev; half_log = VECS[i].hl; step_div = VECS[i].dv;
      cusp_sel = VECS[i].cusp; nominal_word = VECS[i].nom; spread_en = 1'b1;
      @(posedge clk); @(negedge clk);
      chk(ctrl_word == VECS[i].nom, "R5 start word", ctrl_word, VECS[i].nom);
      run_period(VECS[i].dev, VECS[i].hl, VECS[i].dv, VECS[i].cusp, VECS[i].nom, 1, -1, mp, mc);
      chk(mp == int'(VECS[i].per), "R5 period length", mp, VECS[i].per);
      chk(mc == longint'(VECS[i].minw), "R4 deepest word", mc, VECS[i].minw);
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk(ctrl_word == VECS[i].nom, "R2 idle after drop", ctrl_word, VECS[i].nom);
      chk(period_start == 1'b0, "R9 marker idle", period_start, 0);
    end

    // R8: mid-period setting changes wait for the period boundary
    @(negedge clk);
    spread_depth = 16'd400; half_log = 4'd2; step_div = 12'd1; cusp_sel = 1'b0;
    nominal_word = 24'h001000; spread_en = 1'b1;
    @(posedge clk); @(negedge clk);
    run_period(400, 2, 1, 1'b0, 24'h001000, -1, 5, mp, mc);
    chk(mc == 24'h001000 - 400, "R8 old depth kept", mc, 24'h001000 - 400);
    run_period(900, 3, 0, 1'b1, 24'h001000, 1, -1, mp, mc);
    chk(mc == 24'h001000 - 900, "R8 new depth applied", mc, 24'h001000 - 900);
    chk(mp == 16, "R8 new rate applied", mp, 16);

    // R1: reset in mid-sweep
    @(negedge clk);
    spread_depth = 16'd1000; half_log = 4'd3; step_div = 12'd0; cusp_sel = 1'b0;
    nominal_word = 24'h100000; spread_en = 1'b1;
    repeat (6) @(posedge clk);
    @(negedge clk);
    chk(ctrl_word != 24'h100000, "R1 sweep active", ctrl_word, 24'h100000 - 625);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(ctrl_word == 24'h100000, "R1 reset clears offset", ctrl_word, 24'h100000);
    chk(period_start == 1'b0, "R1 reset clears marker", period_start, 0);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(ctrl_word == 24'h100000, "R1 restart from zero", ctrl_word, 24'h100000);
    run_period(1000, 3, 0, 1'b0, 24'h100000, 1, -1, mp, mc);
    chk(mp == 16, "R1 rising restart period", mp, 16);

    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule